// File: doc/BRIEF.md
# Hardwired Memory-to-Memory Subtract Sequencer

This block is a hardwired control unit together with the small datapath it steers. It fetches 24-bit instruction words from a synchronous word-addressed memory and runs them. The datapath holds an instruction address counter, a memory address register (MAR), a memory data register (MDR), an instruction register, and the ALU registers R1, R2 and R3. A one-hot opcode decoder and a timing-state sequencer drive a decode-only pulse distributor, which raises the control points for exactly one step in each clock cycle.

The main instruction is a two-address subtract. It reads the word at the first address and the word at the second address, then writes their two's-complement difference back over the first word. Every subtract runs the same sixteen timing states. The subtrahend is inverted in a step of its own, and the following step adds it to the minuend with a carry-in of one. Two further opcodes set and clear an interrupt-enable flag in the status word. The subtract updates the overflow flag in that word. Every other opcode is a no-op and costs only the four fetch and decode states.

The memory returns read data in the cycle after the read strobe. A write takes effect at the clock edge that ends the write state. The memory address always shows MAR, and the write data always shows MDR.

Top module: `mm_sub_ctrl`

## Requirements
- R1: A synchronous active-high reset clears the instruction address counter, MAR, MDR, the instruction register, R1–R3 and both status flags, and places the sequencer in timing state 0. After reset, `tstate_o` is 0, `mem_addr` is 0, both strobes are low, and the next fetch reads address 0.
- R2: Fetch runs over three steps. In state 0 the address counter is copied to MAR. In state 1 `mem_rd` is high with `mem_addr` equal to the counter. In state 2 the returned word is loaded into MDR and the instruction register, and the counter increments by one.
- R3: The opcode is bits [23:16] of the instruction word. The decoder has one line each for subtract (0x21), interrupt-enable-on (0x30) and interrupt-enable-off (0x31), plus one line for any other value. Exactly one line is active at any time.
- R4: In a subtract, the first address field (bits [15:8]) is read in state 5 and loaded into R1 in state 6. The second address field (bits [7:0]) is read in state 8 and loaded into R2 in state 9.
- R5: The subtract result is first operand minus second operand, modulo 2^24. R2 is inverted in state 10, R1 + R2 + 1 is latched in state 11, and that sum moves to R3 in state 12.
- R6: R3 moves to MDR in state 13, and the first address goes to MAR in state 14. In state 15 `mem_wr` is high with `mem_addr` equal to the first address and `mem_wdata` equal to the result. The word at the second address is left unchanged.
- R7: Each subtract sets the overflow flag when the two operands have different signs and the result's sign differs from the first operand's sign. Otherwise it clears the flag. Other opcodes leave the flag unchanged.
- R8: A subtract steps through timing states 0 to 15 one per cycle. It then returns to state 0 and fetches from the next address.
- R9: An opcode other than 0x21 goes from decode (state 3) straight to state 0. It makes no operand read and no memory write.
- R10: Opcode 0x30 sets the interrupt-enable flag and opcode 0x31 clears it. Each takes effect at the end of the decode state.
- R11: `mem_rd` is high only in states 1, 5 and 8 of a subtract, and only in state 1 otherwise. `mem_wr` is high only in state 15. The two strobes are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_addr | output | 8 | Memory word address (MAR) |
| mem_rd | output | 1 | Read strobe; data returns in the next cycle |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 24 | Write data (MDR) |
| mem_rdata | input | 24 | Read data from memory |
| tstate_o | output | 4 | Current timing state, 0 to 15 |
| ovf_flag | output | 1 | Status word overflow flag |
| ie_flag | output | 1 | Status word interrupt-enable flag |

## Verification
The subtract runs on operand pairs chosen to separate the arithmetic cases:
- a positive result and a negative result;
- equal operands, which give zero;
- both ways of crossing the most-negative and most-positive bounds, which must set overflow;
- two most-negative operands, whose difference must not set overflow.

Each subtract is traced cycle by cycle against the strobe and address schedule, which tells fetch order, operand order and write-back target apart. A mixed program then exercises the remaining behaviour:
- the enable opcodes and a no-op whose address fields point at live data, showing that flags persist and that no operand traffic occurs;
- a counter advance across several instructions;
- a reset in the middle of an instruction, after which the next fetch must come from address 0.

// File: rtl/mmsub_pkg.sv
package mmsub_pkg;

    localparam int OP_W   = 8;
    localparam int ADDR_W = 8;
    localparam int WORD_W = OP_W + 2 * ADDR_W;
    localparam int N_TS   = 16;
    localparam int TS_W   = $clog2(N_TS);

    localparam logic [OP_W-1:0] OPC_SUB   = 8'h21;
    localparam logic [OP_W-1:0] OPC_IEON  = 8'h30;
    localparam logic [OP_W-1:0] OPC_IEOFF = 8'h31;

    // decoder line indices; the "other" line sits above the known ones
    localparam int N_KNOWN   = 3;
    localparam int N_DEC     = N_KNOWN + 1;
    localparam int DEC_SUB   = 0;
    localparam int DEC_IEON  = 1;
    localparam int DEC_IEOFF = 2;
    localparam int DEC_OTHER = N_KNOWN;

    localparam logic [OP_W-1:0] DEC_CODES [N_KNOWN] = '{OPC_SUB, OPC_IEON, OPC_IEOFF};

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [ADDR_W-1:0] addr_t;

    typedef struct packed {
        logic [OP_W-1:0] op;
        addr_t           src_a;
        addr_t           src_b;
    } instr_t;

    typedef struct packed {
        logic ie;
        logic ovf;
    } psw_t;

    typedef enum logic [TS_W-1:0] {
        T_FADDR  = 4'd0,
        T_FRD    = 4'd1,
        T_FLD    = 4'd2,
        T_DEC    = 4'd3,
        T_A_ADDR = 4'd4,
        T_A_RD   = 4'd5,
        T_A_LD   = 4'd6,
        T_B_ADDR = 4'd7,
        T_B_RD   = 4'd8,
        T_B_LD   = 4'd9,
        T_CPL    = 4'd10,
        T_ADD    = 4'd11,
        T_ALU_R3 = 4'd12,
        T_R3_MDR = 4'd13,
        T_WB_ADR = 4'd14,
        T_WR     = 4'd15
    } tstate_e;

    typedef struct packed {
        logic mar_from_iac;
        logic mar_from_a;
        logic mar_from_b;
        logic mem_rd;
        logic mem_wr;
        logic ld_ir;
        logic iac_inc;
        logic ld_r1;
        logic ld_r2;
        logic cpl_r2;
        logic do_add;
        logic ld_r3;
        logic mdr_from_r3;
        logic set_ie;
        logic clr_ie;
    } ctl_t;

    // signed-overflow rule for an addition x + y giving s
    function automatic logic add_ovf(input word_t x, input word_t y, input word_t s);
        return (x[WORD_W-1] == y[WORD_W-1]) && (s[WORD_W-1] != x[WORD_W-1]);
    endfunction

endpackage

// File: rtl/mmsub_decoder.sv
module mmsub_decoder
    import mmsub_pkg::*;
(
    input  logic [OP_W-1:0]  opcode,
    output logic [N_DEC-1:0] lines
);
    logic [N_KNOWN-1:0] hit;

    for (genvar i = 0; i < N_KNOWN; i++) begin : g_line
        assign hit[i] = (opcode == DEC_CODES[i]);
    end

    assign lines = {~|hit, hit};
endmodule

// File: rtl/mmsub_sequencer.sv
module mmsub_sequencer
    import mmsub_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    is_sub,
    output tstate_e tstate
);
    tstate_e nxt;

    always_comb begin
        case (tstate)
            T_DEC:   nxt = is_sub ? T_A_ADDR : T_FADDR;
            T_WR:    nxt = T_FADDR;
            default: nxt = tstate_e'(tstate + 1'b1);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) tstate <= T_FADDR;
        else     tstate <= nxt;
    end
endmodule

// File: rtl/mmsub_distributor.sv
module mmsub_distributor
    import mmsub_pkg::*;
(
    input  tstate_e          tstate,
    input  logic [N_DEC-1:0] dec_lines,
    output ctl_t             ctl
);
    always_comb begin
        ctl = '0;
        case (tstate)
            T_FADDR:  ctl.mar_from_iac = 1'b1;
            T_FRD:    ctl.mem_rd       = 1'b1;
            T_FLD: begin
                ctl.ld_ir   = 1'b1;
                ctl.iac_inc = 1'b1;
            end
            T_DEC: begin
                ctl.set_ie = dec_lines[DEC_IEON];
                ctl.clr_ie = dec_lines[DEC_IEOFF];
            end
            T_A_ADDR: ctl.mar_from_a   = 1'b1;
            T_A_RD:   ctl.mem_rd       = 1'b1;
            T_A_LD:   ctl.ld_r1        = 1'b1;
            T_B_ADDR: ctl.mar_from_b   = 1'b1;
            T_B_RD:   ctl.mem_rd       = 1'b1;
            T_B_LD:   ctl.ld_r2        = 1'b1;
            T_CPL:    ctl.cpl_r2       = 1'b1;
            T_ADD:    ctl.do_add       = 1'b1;
            T_ALU_R3: ctl.ld_r3        = 1'b1;
            T_R3_MDR: ctl.mdr_from_r3  = 1'b1;
            T_WB_ADR: ctl.mar_from_a   = 1'b1;
            T_WR:     ctl.mem_wr       = 1'b1;
            default:  ctl = '0;
        endcase
    end
endmodule

// File: rtl/mmsub_datapath.sv
module mmsub_datapath
    import mmsub_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  ctl_t   ctl,
    input  word_t  mem_rdata,
    output addr_t  mar,
    output word_t  mdr,
    output addr_t  iac,
    output instr_t ir,
    output word_t  r2,
    output psw_t   psw
);
    word_t r1, r3, alu_q, sum;

    // two's-complement add with the subtract carry-in fixed at one
    always_comb sum = r1 + r2 + word_t'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            iac   <= '0;
            mar   <= '0;
            mdr   <= '0;
            ir    <= '0;
            r1    <= '0;
            r2    <= '0;
            r3    <= '0;
            alu_q <= '0;
            psw   <= '0;
        end else begin
            if (ctl.mar_from_iac) mar <= iac;
            if (ctl.mar_from_a)   mar <= ir.src_a;
            if (ctl.mar_from_b)   mar <= ir.src_b;

            // returned word lands in MDR and is forwarded in the same step
            if (ctl.ld_ir || ctl.ld_r1 || ctl.ld_r2) mdr <= mem_rdata;
            if (ctl.mdr_from_r3)                     mdr <= r3;

            if (ctl.ld_ir)   ir  <= instr_t'(mem_rdata);
            if (ctl.iac_inc) iac <= iac + addr_t'(1);
            if (ctl.ld_r1)   r1  <= mem_rdata;
            if (ctl.ld_r2)   r2  <= mem_rdata;
            if (ctl.cpl_r2)  r2  <= ~r2;

            if (ctl.do_add) begin
                alu_q   <= sum;
                psw.ovf <= add_ovf(r1, r2, sum);
            end
            if (ctl.ld_r3)  r3     <= alu_q;
            if (ctl.set_ie) psw.ie <= 1'b1;
            if (ctl.clr_ie) psw.ie <= 1'b0;
        end
    end
endmodule

// File: rtl/mm_sub_ctrl.sv
module mm_sub_ctrl
    import mmsub_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic [TS_W-1:0]   tstate_o,
    output logic              ovf_flag,
    output logic              ie_flag
);
    tstate_e          tstate;
    logic [N_DEC-1:0] dec_lines;
    ctl_t             ctl;
    addr_t            mar;
    word_t            mdr;
    addr_t            iac;
    instr_t           ir;
    word_t            r2;
    psw_t             psw;

    mmsub_decoder u_dec (
        .opcode (ir.op),
        .lines  (dec_lines)
    );

    mmsub_sequencer u_seq (
        .clk    (clk),
        .rst    (rst),
        .is_sub (dec_lines[DEC_SUB]),
        .tstate (tstate)
    );

    mmsub_distributor u_dist (
        .tstate    (tstate),
        .dec_lines (dec_lines),
        .ctl       (ctl)
    );

    mmsub_datapath u_dp (
        .clk       (clk),
        .rst       (rst),
        .ctl       (ctl),
        .mem_rdata (mem_rdata),
        .mar       (mar),
        .mdr       (mdr),
        .iac       (iac),
        .ir        (ir),
        .r2        (r2),
        .psw       (psw)
    );

    assign mem_addr  = mar;
    assign mem_wdata = mdr;
    assign mem_rd    = ctl.mem_rd;
    assign mem_wr    = ctl.mem_wr;
    assign tstate_o  = tstate;
    assign ovf_flag  = psw.ovf;
    assign ie_flag   = psw.ie;
endmodule

// File: rtl/mmsub_checker.sv
module mmsub_checker
    import mmsub_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input tstate_e          tstate,
    input logic [N_DEC-1:0] dec_lines,
    input addr_t            iac,
    input instr_t           ir,
    input word_t            r2,
    input logic             mem_rd,
    input logic             mem_wr
);
    assert_onehot_dec_R3: assert property (@(posedge clk) disable iff (rst)
        $countones(dec_lines) == 1);

    assert_iac_step_R2: assert property (@(posedge clk) disable iff (rst)
        (tstate == T_FLD) |=> (iac == $past(iac) + addr_t'(1)));

    assert_ir_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (tstate != T_FLD) |=> $stable(ir));

    assert_cpl_step_R5: assert property (@(posedge clk) disable iff (rst)
        (tstate == T_CPL) |=> (r2 == ~$past(r2)));

    assert_return_fetch_R8: assert property (@(posedge clk) disable iff (rst)
        (tstate == T_WR) |=> (tstate == T_FADDR));

    assert_skip_exec_R9: assert property (@(posedge clk) disable iff (rst)
        (tstate == T_DEC && !dec_lines[DEC_SUB]) |=> (tstate == T_FADDR));

    assert_strobe_excl_R11: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));
endmodule

bind mm_sub_ctrl mmsub_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .tstate    (tstate),
    .dec_lines (dec_lines),
    .iac       (iac),
    .ir        (ir),
    .r2        (r2),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr)
);

// File: tb/tb_mm_sub_ctrl.sv
module tb_mm_sub_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  mem_addr;
    logic        mem_rd, mem_wr;
    logic [23:0] mem_wdata;
    logic [23:0] mem_rdata = '0;
    logic [3:0]  tstate_o;
    logic        ovf_flag, ie_flag;

    int total = 0;
    int bad   = 0;

    logic [23:0] mem [256];
    logic        ld_en = 1'b0;
    logic [7:0]  ld_addr = '0;
    logic [23:0] ld_data = '0;

    always #10 clk = ~clk;

    mm_sub_ctrl dut (
        .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .tstate_o(tstate_o), .ovf_flag(ovf_flag), .ie_flag(ie_flag)
    );

    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= mem[mem_addr];
        if (mem_wr) mem[mem_addr] <= mem_wdata;
        if (ld_en)  mem[ld_addr] <= ld_data;
    end

    // {first operand, second operand, expected difference, expected overflow}
    localparam logic [72:0] VEC [7] = '{
        {24'h000010, 24'h000003, 24'h00000D, 1'b0},
        {24'h000003, 24'h000010, 24'hFFFFF3, 1'b0},
        {24'h7FFFFF, 24'hFFFFFF, 24'h800000, 1'b1},
        {24'h800000, 24'h000001, 24'h7FFFFF, 1'b1},
        {24'h123456, 24'h123456, 24'h000000, 1'b0},
        {24'h800000, 24'h800000, 24'h000000, 1'b0},
        {24'h000000, 24'h800000, 24'h800000, 1'b1}
    };

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic poke(input logic [7:0] a, input logic [23:0] d);
        ld_en = 1'b1; ld_addr = a; ld_data = d;
        step();
        ld_en = 1'b0;
    endtask

    // traces one instruction from state 0 and checks state, strobe and address per cycle
    task automatic trace(input logic [7:0] pc, input logic [7:0] a, input logic [7:0] b, input bit is_sub);
        int errs = 0;
        int n = is_sub ? 16 : 4;
        logic [31:0] first_act = 0, first_exp = 0;
        for (int c = 0; c < n; c++) begin
            bit exp_rd = (c == 1) || (is_sub && (c == 5 || c == 8));
            bit exp_wr = is_sub && (c == 15);
            logic [7:0] exp_ad = (c == 1) ? pc : (c == 8) ? b : a;
            bit ok = (tstate_o == 4'(c)) && (mem_rd == exp_rd) && (mem_wr == exp_wr) &&
                     (!(exp_rd || exp_wr) || mem_addr == exp_ad);
            if (!ok && errs == 0) begin
                first_act = {tstate_o, 2'b0, mem_rd, mem_wr, 16'h0, mem_addr};
                first_exp = {4'(c), 2'b0, exp_rd, exp_wr, 16'h0, exp_ad};
            end
            if (!ok) errs++;
            step();
        end
        check(errs == 0 && tstate_o == 4'd0,
              is_sub ? "R2/R4/R6/R8/R11 subtract schedule" : "R2/R9/R11 short schedule",
              first_act, first_exp);
    endtask

    initial begin
        #(20 * 100000);
        bad++; total++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1: reset state
        rst = 1'b1;
        poke(8'h00, 24'h000000);
        rst = 1'b0;
        check(tstate_o == 0 && !mem_rd && !mem_wr && mem_addr == 0, "R1 reset outputs",
              {tstate_o, mem_rd, mem_wr, mem_addr}, 0);
        check(!ovf_flag && !ie_flag, "R1 reset flags", {ovf_flag, ie_flag}, 0);

        // vector table: subtract at address 0, operands at 0x40 / 0x41
        foreach (VEC[i]) begin
            logic [23:0] va = VEC[i][72:49];
            logic [23:0] vb = VEC[i][48:25];
            logic [23:0] vr = VEC[i][24:1];
            logic        vo = VEC[i][0];
            rst = 1'b1;
            poke(8'h00, {8'h21, 8'h40, 8'h41});
            poke(8'h40, va);
            poke(8'h41, vb);
            rst = 1'b0;
            trace(8'h00, 8'h40, 8'h41, 1'b1);
            check(mem[8'h40] == vr, "R5 difference written", mem[8'h40], vr);
            check(mem[8'h41] == vb, "R6 second operand kept", mem[8'h41], vb);
            check(ovf_flag == vo, "R7 overflow", ovf_flag, vo);
        end

        // mixed program
        rst = 1'b1;
        poke(8'h00, {8'h30, 8'h00, 8'h00});
        poke(8'h01, {8'h21, 8'h50, 8'h51});
        poke(8'h02, {8'h00, 8'h60, 8'h61});
        poke(8'h03, {8'h31, 8'h00, 8'h00});
        poke(8'h04, {8'h21, 8'h52, 8'h53});
        poke(8'h50, 24'h7FFFFF);
        poke(8'h51, 24'hFFFFFF);
        poke(8'h52, 24'h000005);
        poke(8'h53, 24'h000007);
        poke(8'h60, 24'hABCDEF);
        rst = 1'b0;

        trace(8'h00, 8'h00, 8'h00, 1'b0);
        check(ie_flag == 1'b1, "R10 enable opcode", ie_flag, 1);
        trace(8'h01, 8'h50, 8'h51, 1'b1);
        check(ovf_flag == 1'b1 && ie_flag == 1'b1, "R7 overflow with ie held", {ovf_flag, ie_flag}, 2'b11);
        trace(8'h02, 8'h60, 8'h61, 1'b0);
        check(ovf_flag == 1'b1, "R7 flag kept across no-op", ovf_flag, 1);
        check(mem[8'h60] == 24'hABCDEF, "R9 no-op leaves memory", mem[8'h60], 24'hABCDEF);
        trace(8'h03, 8'h00, 8'h00, 1'b0);
        check(ie_flag == 1'b0, "R10 disable opcode", ie_flag, 0);
        trace(8'h04, 8'h52, 8'h53, 1'b1);
        check(mem[8'h52] == 24'hFFFFFE, "R5 negative result", mem[8'h52], 24'hFFFFFE);
        check(ovf_flag == 1'b0, "R7 overflow cleared", ovf_flag, 0);

        // R1: reset in the middle of a subtract
        rst = 1'b1;
        step();
        rst = 1'b0;
        trace(8'h00, 8'h00, 8'h00, 1'b0);
        for (int k = 0; k < 12; k++) step();
        rst = 1'b1;
        step();
        rst = 1'b0;
        check(tstate_o == 0 && mem_addr == 0 && !ovf_flag && !ie_flag, "R1 mid-instruction reset",
              {tstate_o, mem_addr, ovf_flag, ie_flag}, 0);
        trace(8'h00, 8'h00, 8'h00, 1'b0);
        check(ie_flag == 1'b1, "R1 fetch restarts at address 0", ie_flag, 1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule